// File: doc/BRIEF.md
# Non-Audio Stream Sync Detector

This block sits behind the sample decoder of a digital audio receiver and watches each accepted 16-bit sample. Compressed bursts carried in place of linear audio start with a fixed run of six 16-bit words: four zero words, then 0xF872, then 0x4E1F, in that order and on consecutive accepted samples. When that run is seen, the block raises a detect flag and holds it for a retriggerable window of frames. Each fresh sync restarts the window.

A status output is formed as the OR of the detect flag and bit 1 of the received channel-status block. Downstream logic can then treat the stream as non-audio when either source says so. Samples are forwarded one cycle later, unchanged whatever the detector decides. Muting and burst payload parsing are left to other blocks.

Top module: `nasd_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `auto_det`, `audio_flag` and `out_valid` are 0.
- R2: Every sample accepted with `smp_valid`=1 appears on `out_data` with `out_valid`=1 exactly one cycle later, bit for bit. This holds whether or not non-audio data is detected.
- R3: When the accepted samples, oldest first, are 0x0000, 0x0000, 0x0000, 0x0000, 0xF872, 0x4E1F, `auto_det` is 1 in the cycle after the edge that accepts 0x4E1F.
- R4: A cycle with `smp_valid`=0 neither advances nor breaks a partial match. Any accepted word that differs from the expected next word breaks it, and no detection follows.
- R5: A sync run may start at any sample position, including after a run of more than four zero words.
- R6: With no new sync, `auto_det` falls on the 4096th `frame_stb` edge after the last match. It is still 1 after 4095 of them, and it stays 0 until the next sync.
- R7: A new sync while `auto_det` is 1 restarts the window. A further 4096 frame strobes are then needed to clear it.
- R8: A `frame_stb` in the same cycle as a match is not counted. Frame strobes while `auto_det` is 0 have no effect on the next window.
- R9: `audio_flag` is the OR of `auto_det` and the value of `cs_bit1` one cycle earlier, with the same register timing as `auto_det`.
- R10: Reset clears the sample history, so a sync run cut by a reset does not complete afterwards. A lone 0x4E1F does not detect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample accepted this cycle |
| smp_data | input | 16 | Decoded sample word |
| frame_stb | input | 1 | One pulse per received frame |
| cs_bit1 | input | 1 | Received channel-status bit 1 |
| out_valid | output | 1 | Forwarded sample valid |
| out_data | output | 16 | Forwarded sample, unchanged |
| auto_det | output | 1 | Non-audio sync detected, held for the frame window |
| audio_flag | output | 1 | OR of detect flag and channel-status bit 1 |

## Verification
The assertions assume that `rst` is high from time zero until the first clock edges. They also assume that `frame_stb` and `smp_valid` are single-cycle level inputs sampled at the clock. No particular relation between frames and samples is assumed. The bench drives every input on the falling edge, holds `rst` through the first cycles and keeps `cs_bit1` at a known level. It also resets the block between scenarios, so each sync run starts from an empty history and a cleared window.

// File: rtl/nasd_pkg.sv
package nasd_pkg;
  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned SYNC_LEN = 6;

  // Word expected at position idx of the sync run (0 = oldest).
  function automatic logic [SAMPLE_W-1:0] sync_word(input int unsigned idx);
    logic [SAMPLE_W-1:0] w;
    case (idx)
      4:       w = 16'hF872;
      5:       w = 16'h4E1F;
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/nasd_sync_match.sv
module nasd_sync_match
  import nasd_pkg::*;
#(
  parameter int unsigned LEN = SYNC_LEN
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                hit
);
  localparam int unsigned DEPTH = LEN - 1;

  logic [SAMPLE_W-1:0] hist [DEPTH];
  logic [DEPTH-1:0]    hist_ok;
  logic [DEPTH-1:0]    stage_eq;

  // hist[0] holds the most recent accepted word.
  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          hist[k]    <= '0;
          hist_ok[k] <= 1'b0;
        end else if (in_valid) begin
          hist[k]    <= in_data;
          hist_ok[k] <= 1'b1;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) begin
          hist[k]    <= '0;
          hist_ok[k] <= 1'b0;
        end else if (in_valid) begin
          hist[k]    <= hist[k-1];
          hist_ok[k] <= hist_ok[k-1];
        end
      end
    end
    assign stage_eq[k] = hist_ok[k] && (hist[k] == sync_word(DEPTH - 1 - k));
  end

  assign hit = in_valid && (in_data == sync_word(LEN - 1)) && (&stage_eq);
endmodule

// File: rtl/nasd_hold_timer.sv
module nasd_hold_timer #(
  parameter int unsigned HOLD_FRAMES = 4096,
  localparam int unsigned CNT_W = $clog2(HOLD_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             frame_stb,
  output logic             det_q,
  output logic             det_nxt,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_FRAMES - 1);

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    det_nxt = det_q;
    cnt_nxt = cnt_q;
    if (hit) begin
      det_nxt = 1'b1;
      cnt_nxt = '0;
    end else if (det_q && frame_stb) begin
      if (cnt_q == LAST) begin
        det_nxt = 1'b0;
        cnt_nxt = '0;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      det_q <= det_nxt;
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/nasd_pass.sv
module nasd_pass
  import nasd_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) out_data <= in_data;
  end
endmodule

// File: rtl/nasd_top.sv
module nasd_top
  import nasd_pkg::*;
#(
  parameter int unsigned HOLD_FRAMES = 4096,
  localparam int unsigned CNT_W = $clog2(HOLD_FRAMES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                frame_stb,
  input  logic                cs_bit1,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                auto_det,
  output logic                audio_flag
);
  logic             sync_hit;
  logic             det_nxt;
  logic [CNT_W-1:0] hold_cnt;
  logic             audio_q;

  nasd_sync_match #(.LEN(SYNC_LEN)) u_match (
    .clk      (clk),
    .rst      (rst),
    .in_valid (smp_valid),
    .in_data  (smp_data),
    .hit      (sync_hit)
  );

  nasd_hold_timer #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .hit       (sync_hit),
    .frame_stb (frame_stb),
    .det_q     (auto_det),
    .det_nxt   (det_nxt),
    .cnt_q     (hold_cnt)
  );

  nasd_pass u_pass (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (smp_valid),
    .in_data   (smp_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) audio_q <= 1'b0;
    else     audio_q <= det_nxt | cs_bit1;
  end

  assign audio_flag = audio_q;
endmodule

// File: rtl/nasd_chk.sv
module nasd_chk #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_valid,
  input logic [15:0]      smp_data,
  input logic             frame_stb,
  input logic             cs_bit1,
  input logic             out_valid,
  input logic [15:0]      out_data,
  input logic             auto_det,
  input logic             audio_flag,
  input logic [CNT_W-1:0] hold_cnt
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  // R2
  fwd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> out_valid == $past(smp_valid));

  // R2
  fwd_data_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(smp_valid)) |-> out_data == $past(smp_data));

  // R3
  det_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(auto_det)) |-> ($past(smp_valid) && $past(smp_data) == 16'h4E1F));

  // R6
  det_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $fell(auto_det)) |-> ($past(frame_stb) && hold_cnt == '0));

  // R8
  idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !auto_det |-> hold_cnt == '0);

  // R9
  audio_or_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> audio_flag == (auto_det | $past(cs_bit1)));
endmodule

bind nasd_top nasd_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .smp_valid  (smp_valid),
  .smp_data   (smp_data),
  .frame_stb  (frame_stb),
  .cs_bit1    (cs_bit1),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .auto_det   (auto_det),
  .audio_flag (audio_flag),
  .hold_cnt   (hold_cnt)
);

// File: tb/sim_nasd_top.sv
module sim_nasd_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        frame_stb = 1'b0;
  logic        cs_bit1 = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        auto_det;
  logic        audio_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_q [$];

  always #10 clk = ~clk;

  nasd_top u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .frame_stb(frame_stb), .cs_bit1(cs_bit1), .out_valid(out_valid),
    .out_data(out_data), .auto_det(auto_det), .audio_flag(audio_flag)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected forwarded sample (R2)
  always @(negedge clk) begin
    if (!rst && out_valid === 1'b1) begin
      if (exp_q.size() == 0) check("R2 unexpected out_valid", 16'h1, 16'h0);
      else check("R2 forwarded sample", out_data, exp_q.pop_front());
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0; frame_stb = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w, input logic with_frame = 1'b0);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = w; frame_stb = with_frame;
    exp_q.push_back(w);
    @(negedge clk);
    smp_valid = 1'b0; frame_stb = 1'b0;
  endtask

  task automatic send_sync(input logic frame_last = 1'b0);
    for (int i = 0; i < 4; i++) send_word(16'h0000);
    send_word(16'hF872);
    send_word(16'h4E1F, frame_last);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_stb = 1'b1;
      @(negedge clk); frame_stb = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 auto_det in reset", {15'd0, auto_det}, 16'd0);
    check("R1 audio_flag in reset", {15'd0, audio_flag}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", {15'd0, out_valid}, 16'd0);
    check("R1 auto_det after reset", {15'd0, auto_det}, 16'd0);

    // R3 basic detection, R2 forwarding of sync words
    send_sync();
    check("R3 detect after sync", {15'd0, auto_det}, 16'd1);
    check("R9 audio from detect", {15'd0, audio_flag}, 16'd1);

    // R6 window length
    frames(4095);
    check("R6 still set after 4095 frames", {15'd0, auto_det}, 16'd1);
    frames(1);
    check("R6 cleared on 4096th frame", {15'd0, auto_det}, 16'd0);
    send_word(16'h1234);
    check("R6 stays low without sync", {15'd0, auto_det}, 16'd0);

    // R9 channel-status path
    @(negedge clk); cs_bit1 = 1'b1;
    @(negedge clk);
    check("R9 audio from cs bit", {15'd0, audio_flag}, 16'd1);
    cs_bit1 = 1'b0;
    @(negedge clk);
    check("R9 audio low", {15'd0, audio_flag}, 16'd0);

    // R7 retrigger
    send_sync();
    frames(3000);
    send_sync();
    frames(3000);
    check("R7 set after retrigger", {15'd0, auto_det}, 16'd1);
    frames(1095);
    check("R7 still set at 4095", {15'd0, auto_det}, 16'd1);
    frames(1);
    check("R7 cleared at 4096", {15'd0, auto_det}, 16'd0);

    // R8 idle strobes ignored, strobe in match cycle not counted
    frames(20);
    send_sync(1'b1);
    frames(4095);
    check("R8 set after 4095 with strobe on match", {15'd0, auto_det}, 16'd1);
    frames(1);
    check("R8 cleared at 4096", {15'd0, auto_det}, 16'd0);

    // R4 mismatch breaks
    do_reset();
    for (int i = 0; i < 4; i++) send_word(16'h0000);
    send_word(16'h0001);
    send_word(16'hF872);
    send_word(16'h4E1F);
    check("R4 mismatch no detect", {15'd0, auto_det}, 16'd0);

    // R4 gaps in valid do not break
    for (int i = 0; i < 4; i++) begin
      send_word(16'h0000);
      repeat (2) @(negedge clk);
    end
    send_word(16'hF872);
    repeat (3) @(negedge clk);
    send_word(16'h4E1F);
    check("R4 detect across idle cycles", {15'd0, auto_det}, 16'd1);

    // R5 long zero run
    do_reset();
    for (int i = 0; i < 9; i++) send_word(16'h0000);
    send_word(16'hF872);
    send_word(16'h4E1F);
    check("R5 detect after long zero run", {15'd0, auto_det}, 16'd1);

    // R10 reset clears history; lone final word
    do_reset();
    for (int i = 0; i < 4; i++) send_word(16'h0000);
    send_word(16'hF872);
    do_reset();
    send_word(16'h4E1F);
    check("R10 no detect across reset", {15'd0, auto_det}, 16'd0);
    send_word(16'h4E1F);
    check("R10 lone word no detect", {15'd0, auto_det}, 16'd0);

    repeat (3) @(negedge clk);
    check("R2 queue drained", 16'(exp_q.size()), 16'd0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule